// File: doc/BRIEF.md
# Programmable GPIO Port Controller

This block manages a port of general-purpose I/O lines (32 by default). Each line is either kept by the controller or handed over to an on-chip peripheral. When the controller owns a line, software selects its direction and whether it drives push-pull or open-drain. It sets and clears the output level through separate write-one operations, so a read-modify-write is never needed. When a peripheral owns a line, the peripheral's own value and enable reach the pad unchanged.

The pad side is modelled as three vectors: an output value, an output enable and the raw pad input. The input passes through a two-flop synchronizer. The synchronized level can always be read back, whatever the ownership. Every line also has a sticky change flag, and it keeps working while a peripheral owns the line. The flags that are unmasked are ORed into one interrupt output. A simple register bus gives access to the block: one write strobe, one read strobe, a word address, write data and read data that follows the address combinationally. Reading the change register clears the flags that were set.

Top module: `gpio_port`

## Requirements
- R1: After reset, every line is owned by the controller and is an input. The output data, open-drain, interrupt-mask and change registers are all zero, `padOe` is zero and `irq` is low.
- R2: Register word addresses are as follows. Ownership: 0 take, 1 release, 2 status. Direction: 3 make output, 4 make input, 5 status. Output data: 6 set, 7 clear, 8 status. Open-drain: 9 on, 10 off, 11 status. Interrupt mask: 12 on, 13 off, 14 status. Pin level: 15. Change flags: 16. Any other address, and every write-only address, reads as zero.
- R3: In a take/release, make-output/make-input, open-drain on/off or mask on/off write, each 1 bit acts on its line and each 0 bit leaves that line unchanged. The matching status address then reads the result.
- R4: A write to the set address sets the output data bits given by the ones in the data. A write to the clear address clears those bits. Zero bits in either write leave the line unchanged.
- R5: A controller-owned output line that is not open-drain drives `padOe`=1 and `padOut` equal to its output data bit.
- R6: A controller-owned input line drives `padOe`=0.
- R7: A peripheral-owned line passes `perOut` to `padOut` and `perOe` to `padOe`.
- R8: A controller-owned output line in open-drain mode drives `padOut`=0 and asserts `padOe` only while its output data bit is 0.
- R9: The pin-level register (address 15) returns `padIn` as it was sampled two clock edges earlier, for every line, whatever its ownership.
- R10: A level change of the synchronized input sets that line's change flag at the next edge. The flag stays set until it is cleared, and this also happens for peripheral-owned lines.
- R11: A read of the change register (address 16 with `rdEn` high) returns the flags and clears them at that clock edge. A change detected at that same edge leaves its flag set.
- R12: `irq` is high exactly when some line has both its change flag and its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (needed for read-to-clear) |
| addr | input | 5 | Register word address |
| wrData | input | 32 | Write data, one bit per line |
| rdData | output | 32 | Read data for `addr` |
| padIn | input | 32 | Raw pad input levels |
| padOut | output | 32 | Pad output values |
| padOe | output | 32 | Pad output enables |
| perOut | input | 32 | Peripheral output values |
| perOe | input | 32 | Peripheral output enables |
| irq | output | 1 | Input-change interrupt |

## Verification
The hardest case to reach from the ports is a read of the change register landing on the same edge that a new change is detected. Clearing and setting then compete for one flag. The stimulus reaches this case by counting synchronizer edges. It moves a pad input at a known point and places a change-register read exactly two edges later. It also toggles a peripheral-owned line, which proves that detection does not depend on ownership. A reference model compares the pad, read-data and interrupt outputs against the design on every clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    RA_OWN_TAKE = 5'd0,  RA_OWN_GIVE = 5'd1,  RA_OWN_STAT = 5'd2,
    RA_DIR_OUT  = 5'd3,  RA_DIR_IN   = 5'd4,  RA_DIR_STAT = 5'd5,
    RA_LVL_SET  = 5'd6,  RA_LVL_CLR  = 5'd7,  RA_LVL_STAT = 5'd8,
    RA_OD_ON    = 5'd9,  RA_OD_OFF   = 5'd10, RA_OD_STAT  = 5'd11,
    RA_MSK_ON   = 5'd12, RA_MSK_OFF  = 5'd13, RA_MSK_STAT = 5'd14,
    RA_PIN      = 5'd15, RA_CHG      = 5'd16
  } regAddrE;

  // Strobes from the bus decoder to the datapath
  typedef struct packed {
    logic ownSet;
    logic ownClr;
    logic dirSet;
    logic dirClr;
    logic lvlSet;
    logic lvlClr;
    logic odSet;
    logic odClr;
    logic mskSet;
    logic mskClr;
    logic chgRead;
  } strobeT;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_LINES-1:0]  ownQ,
  input  logic [NUM_LINES-1:0]  dirQ,
  input  logic [NUM_LINES-1:0]  lvlQ,
  input  logic [NUM_LINES-1:0]  odQ,
  input  logic [NUM_LINES-1:0]  mskQ,
  input  logic [NUM_LINES-1:0]  pinQ,
  input  logic [NUM_LINES-1:0]  chgQ,
  output strobeT                strb,
  output logic [NUM_LINES-1:0]  rdData
);

  regAddrE regSel;
  assign regSel = regAddrE'(addr);

  // write decode
  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (regSel)
        RA_OWN_TAKE: strb.ownSet = 1'b1;
        RA_OWN_GIVE: strb.ownClr = 1'b1;
        RA_DIR_OUT:  strb.dirSet = 1'b1;
        RA_DIR_IN:   strb.dirClr = 1'b1;
        RA_LVL_SET:  strb.lvlSet = 1'b1;
        RA_LVL_CLR:  strb.lvlClr = 1'b1;
        RA_OD_ON:    strb.odSet  = 1'b1;
        RA_OD_OFF:   strb.odClr  = 1'b1;
        RA_MSK_ON:   strb.mskSet = 1'b1;
        RA_MSK_OFF:  strb.mskClr = 1'b1;
        default:     ;
      endcase
    end
    strb.chgRead = rdEn && (regSel == RA_CHG);
  end

  // read mux
  always_comb begin
    case (regSel)
      RA_OWN_STAT: rdData = ownQ;
      RA_DIR_STAT: rdData = dirQ;
      RA_LVL_STAT: rdData = lvlQ;
      RA_OD_STAT:  rdData = odQ;
      RA_MSK_STAT: rdData = mskQ;
      RA_PIN:      rdData = pinQ;
      RA_CHG:      rdData = chgQ;
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobeT                strb,
  input  logic [NUM_LINES-1:0]  wrData,
  input  logic [NUM_LINES-1:0]  padIn,
  input  logic [NUM_LINES-1:0]  perOut,
  input  logic [NUM_LINES-1:0]  perOe,
  output logic [NUM_LINES-1:0]  padOut,
  output logic [NUM_LINES-1:0]  padOe,
  output logic [NUM_LINES-1:0]  ownQ,
  output logic [NUM_LINES-1:0]  dirQ,
  output logic [NUM_LINES-1:0]  lvlQ,
  output logic [NUM_LINES-1:0]  odQ,
  output logic [NUM_LINES-1:0]  mskQ,
  output logic [NUM_LINES-1:0]  pinQ,
  output logic [NUM_LINES-1:0]  chgQ,
  output logic                  irq
);

  localparam int LAST = SYNC_STAGES - 1;

  function automatic logic [NUM_LINES-1:0] applyOp(
    input logic [NUM_LINES-1:0] cur,
    input logic                 setOp,
    input logic                 clrOp,
    input logic [NUM_LINES-1:0] bits
  );
    logic [NUM_LINES-1:0] setMask, clrMask;
    setMask = setOp ? bits : '0;
    clrMask = clrOp ? bits : '0;
    return (cur | setMask) & ~clrMask;
  endfunction

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ownQ <= '1;
      dirQ <= '0;
      lvlQ <= '0;
      odQ  <= '0;
      mskQ <= '0;
    end else begin
      ownQ <= applyOp(ownQ, strb.ownSet, strb.ownClr, wrData);
      dirQ <= applyOp(dirQ, strb.dirSet, strb.dirClr, wrData);
      lvlQ <= applyOp(lvlQ, strb.lvlSet, strb.lvlClr, wrData);
      odQ  <= applyOp(odQ,  strb.odSet,  strb.odClr,  wrData);
      mskQ <= applyOp(mskQ, strb.mskSet, strb.mskClr, wrData);
    end
  end

  // input synchronizer chain
  logic [NUM_LINES-1:0] syncQ [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= padIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinQ = syncQ[LAST];

  // change detection
  logic [NUM_LINES-1:0] prevQ;
  logic [NUM_LINES-1:0] edgeHit;

  assign edgeHit = pinQ ^ prevQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevQ <= '0;
      chgQ  <= '0;
    end else begin
      prevQ <= pinQ;
      chgQ  <= (strb.chgRead ? '0 : chgQ) | edgeHit;
    end
  end

  assign irq = |(chgQ & mskQ);

  // per-line pad mux
  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_pad
      always_comb begin
        if (ownQ[i]) begin
          padOut[i] = lvlQ[i] & ~odQ[i];
          padOe[i]  = dirQ[i] & (~odQ[i] | ~lvlQ[i]);
        end else begin
          padOut[i] = perOut[i];
          padOe[i]  = perOe[i];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_LINES-1:0]  wrData,
  output logic [NUM_LINES-1:0]  rdData,
  input  logic [NUM_LINES-1:0]  padIn,
  output logic [NUM_LINES-1:0]  padOut,
  output logic [NUM_LINES-1:0]  padOe,
  input  logic [NUM_LINES-1:0]  perOut,
  input  logic [NUM_LINES-1:0]  perOe,
  output logic                  irq
);

  strobeT               strb;
  logic [NUM_LINES-1:0] ownQ, dirQ, lvlQ, odQ, mskQ, pinQ, chgQ;

  gpio_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .ownQ   (ownQ),
    .dirQ   (dirQ),
    .lvlQ   (lvlQ),
    .odQ    (odQ),
    .mskQ   (mskQ),
    .pinQ   (pinQ),
    .chgQ   (chgQ),
    .strb   (strb),
    .rdData (rdData)
  );

  gpio_datapath #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(2)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .wrData (wrData),
    .padIn  (padIn),
    .perOut (perOut),
    .perOe  (perOe),
    .padOut (padOut),
    .padOe  (padOe),
    .ownQ   (ownQ),
    .dirQ   (dirQ),
    .lvlQ   (lvlQ),
    .odQ    (odQ),
    .mskQ   (mskQ),
    .pinQ   (pinQ),
    .chgQ   (chgQ),
    .irq    (irq)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  rdEn,
  input logic [ADDR_W-1:0]     addr,
  input logic [NUM_LINES-1:0]  padIn,
  input logic [NUM_LINES-1:0]  padOut,
  input logic [NUM_LINES-1:0]  padOe,
  input logic [NUM_LINES-1:0]  perOut,
  input logic [NUM_LINES-1:0]  perOe,
  input logic [NUM_LINES-1:0]  ownQ,
  input logic [NUM_LINES-1:0]  dirQ,
  input logic [NUM_LINES-1:0]  mskQ,
  input logic [NUM_LINES-1:0]  pinQ,
  input logic [NUM_LINES-1:0]  chgQ,
  input logic                  irq
);

  logic [1:0] sinceRst;
  logic       chgRd;

  assign chgRd = rdEn && (addr == RA_CHG);

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  // R7
  per_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (((padOe ^ perOe) | (padOut ^ perOut)) & ~ownQ) == '0);

  // R6
  input_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (padOe & ownQ & ~dirQ) == '0);

  // R9
  pin_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd2) |-> (pinQ == $past(padIn, 2)));

  // R11
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !chgRd |=> ((chgQ & $past(chgQ)) == $past(chgQ)));

  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (mskQ == '0) |-> !irq);

endmodule

bind gpio_port gpio_port_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rdEn   (rdEn),
  .addr   (addr),
  .padIn  (padIn),
  .padOut (padOut),
  .padOe  (padOe),
  .perOut (perOut),
  .perOe  (perOe),
  .ownQ   (ownQ),
  .dirQ   (dirQ),
  .mskQ   (mskQ),
  .pinQ   (pinQ),
  .chgQ   (chgQ),
  .irq    (irq)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;

  localparam int N = 32;
  localparam logic [4:0] A_TAKE = 0, A_GIVE = 1, A_OWNS = 2, A_OUT = 3, A_IN = 4,
    A_DIRS = 5, A_SET = 6, A_CLR = 7, A_LVLS = 8, A_ODON = 9, A_ODOFF = 10,
    A_ODS = 11, A_MON = 12, A_MOFF = 13, A_MSKS = 14, A_PIN = 15, A_CHG = 16;

  logic clk = 0, rst = 1, wrEn = 0, rdEn = 0;
  logic [4:0] addr = 0;
  logic [N-1:0] wrData = 0, rdData, padIn = 0, padOut, padOe, perOut = 0, perOe = 0;
  logic irq;

  int total = 0, bad = 0;
  bit done = 0, started = 0;

  always #4 clk = ~clk;

  gpio_port u0 (.clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .perOut(perOut), .perOe(perOe), .irq(irq));

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [N-1:0] mOwn, mDir, mLvl, mOd, mMsk, mChg;
  logic [N-1:0] hist[$];

  always @(posedge clk) begin
    logic [N-1:0] seen;
    if (rst) begin
      mOwn = '1; mDir = 0; mLvl = 0; mOd = 0; mMsk = 0; mChg = 0;
      hist = '{0, 0, 0};
      started = 1;
    end else begin
      seen = hist[1] ^ hist[2];
      if (rdEn && addr == A_CHG) mChg = 0;
      mChg = mChg | seen;
      hist.push_front(padIn);
      void'(hist.pop_back());
      if (wrEn) begin
        case (addr)
          A_TAKE:  mOwn = mOwn | wrData;
          A_GIVE:  mOwn = mOwn & ~wrData;
          A_OUT:   mDir = mDir | wrData;
          A_IN:    mDir = mDir & ~wrData;
          A_SET:   mLvl = mLvl | wrData;
          A_CLR:   mLvl = mLvl & ~wrData;
          A_ODON:  mOd  = mOd | wrData;
          A_ODOFF: mOd  = mOd & ~wrData;
          A_MON:   mMsk = mMsk | wrData;
          A_MOFF:  mMsk = mMsk & ~wrData;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    logic [N-1:0] eOut, eOe, eRd;
    if (started) begin
      for (int i = 0; i < N; i++) begin
        if (!mOwn[i]) begin
          eOut[i] = perOut[i]; eOe[i] = perOe[i];            // R7
        end else if (!mDir[i]) begin
          eOut[i] = mOd[i] ? 1'b0 : mLvl[i]; eOe[i] = 1'b0;  // R6
        end else if (mOd[i]) begin
          eOut[i] = 1'b0; eOe[i] = !mLvl[i];                 // R8
        end else begin
          eOut[i] = mLvl[i]; eOe[i] = 1'b1;                  // R5
        end
      end
      case (addr)
        A_OWNS: eRd = mOwn;
        A_DIRS: eRd = mDir;
        A_LVLS: eRd = mLvl;
        A_ODS:  eRd = mOd;
        A_MSKS: eRd = mMsk;
        A_PIN:  eRd = hist[1];
        A_CHG:  eRd = mChg;
        default: eRd = 0;
      endcase
      chk("R5/R6/R7/R8 padOut", padOut, eOut);
      chk("R5/R6/R7/R8 padOe", padOe, eOe);
      chk("R2/R9/R10 rdData", rdData, eRd);
      chk("R12 irq", {31'b0, irq}, {31'b0, |(mChg & mMsk)});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
    @(posedge clk); #1;
    wrEn = 1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 0; addr = A_PIN + 5'd2;
  endtask

  task automatic rd(input logic [4:0] a, output logic [N-1:0] v);
    @(posedge clk); #1;
    addr = a; rdEn = 1;
    @(negedge clk);
    v = rdData;
    @(posedge clk); #1;
    rdEn = 0; addr = A_PIN + 5'd2;
  endtask

  initial begin
    logic [N-1:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R1 padOe", padOe, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(A_OWNS, v); chk("R1 own", v, '1);
    rd(A_DIRS, v); chk("R1 dir", v, 0);
    rd(A_CHG, v);  chk("R1 chg", v, 0);

    // R3 / R5: outputs on low byte
    wr(A_OUT, 32'h0000_00FF);
    rd(A_DIRS, v); chk("R3 dir status", v, 32'h0000_00FF);
    wr(A_SET, 32'h0000_000F);
    @(negedge clk);
    chk("R5 pad oe", padOe & 32'hFF, 32'hFF);
    chk("R5 pad out", padOut & 32'hFF, 32'h0F);
    wr(A_CLR, 32'h0000_0003);
    rd(A_LVLS, v); chk("R4 clear", v, 32'h0000_000C);
    wr(A_SET, 32'h0);
    rd(A_LVLS, v); chk("R4 zero write", v, 32'h0000_000C);
    wr(A_IN, 32'h0000_0080);
    @(negedge clk); chk("R6 input line", padOe & 32'h80, 0);

    // R7: lines 8..11 to the peripheral
    wr(A_GIVE, 32'h0000_0F00);
    rd(A_OWNS, v); chk("R3 own status", v, ~32'h0000_0F00);
    perOut = 32'h0000_0A00; perOe = 32'h0000_0600;
    @(negedge clk);
    chk("R7 pad out", padOut & 32'hF00, 32'hA00);
    chk("R7 pad oe", padOe & 32'hF00, 32'h600);

    // R8: open-drain on lines 4,5 (levels 0)
    wr(A_ODON, 32'h0000_0030);
    @(negedge clk);
    chk("R8 drive low", padOe & 32'h30, 32'h30);
    chk("R8 out zero", padOut & 32'h30, 0);
    wr(A_SET, 32'h0000_0010);
    @(negedge clk);
    chk("R8 release", padOe & 32'h30, 32'h20);

    // R9/R10/R12: change on peripheral-owned line 8, unmasked line 20
    wr(A_MON, 32'h0000_0100);
    @(posedge clk); #1 padIn = 32'h0010_0100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 irq raised", {31'b0, irq}, 1);
    rd(A_PIN, v); chk("R9 pin level", v, 32'h0010_0100);
    rd(A_CHG, v); chk("R10 flags", v, 32'h0010_0100);
    @(negedge clk);
    chk("R11 cleared", {31'b0, irq}, 0);
    rd(A_CHG, v); chk("R11 empty", v, 0);

    // R11: read lands on the edge where a new change is detected
    @(posedge clk); #1 padIn = 32'h0010_0108;
    // edge 1: first stage, edge 2: pin, edge 3: flag set
    @(posedge clk); #1 addr = A_CHG; rdEn = 1;
    @(posedge clk); #1;
    @(posedge clk); #1 rdEn = 0;
    rd(A_CHG, v); chk("R11 same-edge change kept", v, 32'h0000_0008);

    wr(A_MOFF, 32'h0000_0100);
    @(posedge clk); #1 padIn = 32'h0;
    repeat (4) @(posedge clk);
    @(negedge clk); chk("R12 masked", {31'b0, irq}, 0);
    rd(A_MSKS, v); chk("R3 mask status", v, 0);
    rd(A_SET, v); chk("R2 write-only reads zero", v, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule